// File: doc/BRIEF.md
# Request Tag Remapping Allocator

This block sits between several read requesters and a link that needs every outstanding read to carry a distinct tag. Each requester names its reads with a pair: its own unit number and a tag that only has meaning inside that unit. Two units may use the same local tag at once. The link, however, needs one shared tag space. A global tag must not be reused while a read that holds it still waits for its completion.

When a read request is accepted, the block hands it the lowest-numbered free global tag. It writes the requester's unit number and local tag into a mapping table entry indexed by that global tag. When a completion comes back, the block looks up its global tag in the same cycle and returns the original unit number and local tag. The tag returns to the free pool on the final part of the completion. A credit counter tracks free space in the response buffer that lies downstream. A request is accepted only if a tag is free and the remaining credit covers the request's expected response size. The buffer therefore never overflows. Credit comes back through a separate release input as the buffer drains.

Acceptance is tracked by a two-state gate machine. GATE_IDLE means no stalled request is pending. GATE_HELD means a request was presented and refused at the last clock edge. The transitions are:
- STALL: from GATE_IDLE to GATE_HELD, taken when a request is valid and not ready.
- GRANT: from GATE_HELD to GATE_IDLE, taken when the held request is accepted.
- WAIT: GATE_HELD stays in GATE_HELD while the request remains refused.
- PASS: GATE_IDLE stays in GATE_IDLE otherwise.

Top module: `tag_remap_alloc`

## Requirements
- R1: After reset all global tags are free and the credit counter holds the full capacity (64 by default). A request whose size equals the whole capacity is therefore ready and receives global tag 0.
- R2: An accepted request (req_valid and req_ready both high at a clock edge) receives, on req_gtag in that same cycle, the lowest-numbered global tag that is free. That tag stays busy from the next cycle on.
- R3: On acceptance, the unit number and local tag are stored at the entry of the assigned global tag. While cpl_valid is high for an outstanding tag, cpl_unit and cpl_ltag show the stored pair in the same cycle.
- R4: A completion with cpl_last high frees its global tag from the next cycle on. A completion with cpl_last low leaves the tag busy.
- R5: A tag freed in a given cycle is not assigned to a request accepted in that same cycle.
- R6: When no global tag is free, req_ready is low.
- R7: req_ready is low whenever the credit count is below req_size. Each accepted request subtracts req_size from the count.
- R8: A credit release (crd_rel_valid) adds crd_rel_amt to the count. The added credit becomes usable in the next cycle, not the current one. The count never exceeds the capacity.
- R9: A completion whose global tag is not outstanding gives cpl_hit low and changes neither the pool nor the table. For an outstanding tag, cpl_hit is high.
- R10: A request refused at a clock edge stays valid, with unit, local tag and size unchanged, until it is accepted. This is an input rule, and it is checked.
- R11: A global tag is never assigned while it is already outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request present |
| req_unit | input | UNIT_W | Requester unit number |
| req_ltag | input | LTAG_W | Requester-local tag |
| req_size | input | CRED_W | Expected response size in credits |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_gtag | output | TAG_W | Global tag assigned to the request |
| cpl_valid | input | 1 | Completion present |
| cpl_gtag | input | TAG_W | Global tag of the completion |
| cpl_last | input | 1 | Final part of the completion |
| cpl_hit | output | 1 | Completion tag is outstanding |
| cpl_unit | output | UNIT_W | Restored unit number |
| cpl_ltag | output | LTAG_W | Restored local tag |
| crd_rel_valid | input | 1 | Response buffer returns credit |
| crd_rel_amt | input | CRED_W | Amount of credit returned |

## Verification
The bench targets the following corner cases:
- Same-cycle reuse: a tag released in the very cycle a request arrives. A design that recycles freed tags too early would hand out tag 0 a cycle ahead and break the expected tag sequence.
- Non-final completions: a completion part that is not the last. A design that frees on any part would wake a request starved of tags too soon.
- Late credit: a credit release that arrives in the same cycle as a request that needs it. A design that adds released credit combinationally would accept that request a cycle early.
- Exact boundaries: a completion for a tag that is not outstanding, full pool exhaustion at exactly 32 requests, and a request that uses the full capacity. An off-by-one in the free pool or the credit compare shows up as a wrong ready level or a wrong tag.

// File: rtl/tag_remap_pkg.sv
package tag_remap_pkg;

    typedef enum logic [0:0] {
        GATE_IDLE = 1'b0,
        GATE_HELD = 1'b1
    } gate_state_t;

endpackage

// File: rtl/tag_pool.sv
module tag_pool #(
    parameter int NUM_TAGS = 32,
    localparam int TAG_W = $clog2(NUM_TAGS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                alloc_en,
    input  logic                rel_en,
    input  logic [TAG_W-1:0]    rel_tag,
    output logic                any_free,
    output logic [TAG_W-1:0]    sel_tag,
    output logic [NUM_TAGS-1:0] free_map
);

    logic [NUM_TAGS-1:0] free_q;
    logic [NUM_TAGS-1:0] set_vec;
    logic [NUM_TAGS-1:0] clr_vec;

    // Lowest free entry wins; scanning downward lets the lowest overwrite.
    always_comb begin
        sel_tag = '0;
        for (int i = NUM_TAGS - 1; i >= 0; i--) begin
            if (free_q[i]) sel_tag = TAG_W'(i);
        end
    end

    assign any_free = |free_q;
    assign free_map = free_q;

    for (genvar g = 0; g < NUM_TAGS; g++) begin : g_bit
        assign set_vec[g] = rel_en   && (rel_tag == TAG_W'(g));
        assign clr_vec[g] = alloc_en && (sel_tag == TAG_W'(g));
    end

    // Allocation always looks at free_q from before this edge, so a tag
    // released now is only visible to requests from the next cycle on.
    always_ff @(posedge clk) begin
        if (!rst_n) free_q <= '1;
        else        free_q <= (free_q & ~clr_vec) | set_vec;
    end

    a_r11_unique: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> free_q[sel_tag]);

    a_r2_lowest: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> ((free_q & ~({NUM_TAGS{1'b1}} << sel_tag)) == '0));

    a_r2_claimed: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |=> !free_q[$past(sel_tag)]);

    a_r4_freed: assert property (@(posedge clk) disable iff (!rst_n)
        rel_en |=> free_q[$past(rel_tag)]);

endmodule

// File: rtl/credit_counter.sv
module credit_counter #(
    parameter int CAPACITY = 64,
    localparam int CRED_W = $clog2(CAPACITY + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_en,
    input  logic [CRED_W-1:0] take_amt,
    input  logic              give_en,
    input  logic [CRED_W-1:0] give_amt,
    output logic [CRED_W-1:0] credits
);

    logic [CRED_W-1:0] cred_q;
    logic [CRED_W-1:0] take_v;
    logic [CRED_W-1:0] give_v;

    assign take_v  = take_en ? take_amt : '0;
    assign give_v  = give_en ? give_amt : '0;
    assign credits = cred_q;

    always_ff @(posedge clk) begin
        if (!rst_n) cred_q <= CRED_W'(CAPACITY);
        else        cred_q <= cred_q - take_v + give_v;
    end

    a_r8_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cred_q <= CRED_W'(CAPACITY));

    a_r7_cover: assert property (@(posedge clk) disable iff (!rst_n)
        take_en |-> (cred_q >= take_amt));

    a_r8_give: assert property (@(posedge clk) disable iff (!rst_n)
        (give_en && !take_en) |=> (cred_q == $past(cred_q) + $past(give_amt)));

endmodule

// File: rtl/map_table.sv
module map_table #(
    parameter int NUM_TAGS = 32,
    parameter int UNIT_W   = 4,
    parameter int LTAG_W   = 8,
    localparam int TAG_W   = $clog2(NUM_TAGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [UNIT_W-1:0] wr_unit,
    input  logic [LTAG_W-1:0] wr_ltag,
    input  logic [TAG_W-1:0]  rd_tag,
    output logic [UNIT_W-1:0] rd_unit,
    output logic [LTAG_W-1:0] rd_ltag
);

    logic [UNIT_W-1:0] unit_q [NUM_TAGS];
    logic [LTAG_W-1:0] ltag_q [NUM_TAGS];
    logic [NUM_TAGS-1:0] wr_hit;

    for (genvar g = 0; g < NUM_TAGS; g++) begin : g_dec
        assign wr_hit[g] = wr_en && (wr_tag == TAG_W'(g));
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_TAGS; i++) begin
            if (wr_hit[i]) begin
                unit_q[i] <= wr_unit;
                ltag_q[i] <= wr_ltag;
            end
        end
    end

    assign rd_unit = unit_q[rd_tag];
    assign rd_ltag = ltag_q[rd_tag];

    a_r3_stored: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (unit_q[$past(wr_tag)] == $past(wr_unit)) &&
                  (ltag_q[$past(wr_tag)] == $past(wr_ltag)));

endmodule

// File: rtl/req_gate.sv
module req_gate
    import tag_remap_pkg::*;
#(
    parameter int UNIT_W   = 4,
    parameter int LTAG_W   = 8,
    parameter int CAPACITY = 64,
    localparam int CRED_W  = $clog2(CAPACITY + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [UNIT_W-1:0] req_unit,
    input  logic [LTAG_W-1:0] req_ltag,
    input  logic [CRED_W-1:0] req_size,
    input  logic              tag_avail,
    input  logic [CRED_W-1:0] credits,
    output logic              req_ready,
    output logic              accept
);

    gate_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= GATE_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        req_ready = tag_avail && (credits >= req_size);
        accept    = req_valid && req_ready;
        state_d   = state_q;
        unique case (state_q)
            GATE_IDLE: if (req_valid && !req_ready) state_d = GATE_HELD; // STALL
            GATE_HELD: if (accept)                  state_d = GATE_IDLE; // GRANT
            default:                                state_d = GATE_IDLE;
        endcase
    end

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GATE_HELD) |-> (req_valid && $stable(req_unit) &&
                                    $stable(req_ltag) && $stable(req_size)));

    a_r6_no_tag: assert property (@(posedge clk) disable iff (!rst_n)
        !tag_avail |-> !req_ready);

    a_r7_short: assert property (@(posedge clk) disable iff (!rst_n)
        (credits < req_size) |-> !accept);

endmodule

// File: rtl/tag_remap_alloc.sv
module tag_remap_alloc #(
    parameter int NUM_TAGS = 32,
    parameter int UNIT_W   = 4,
    parameter int LTAG_W   = 8,
    parameter int CAPACITY = 64,
    localparam int TAG_W   = $clog2(NUM_TAGS),
    localparam int CRED_W  = $clog2(CAPACITY + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [UNIT_W-1:0] req_unit,
    input  logic [LTAG_W-1:0] req_ltag,
    input  logic [CRED_W-1:0] req_size,
    output logic              req_ready,
    output logic [TAG_W-1:0]  req_gtag,
    input  logic              cpl_valid,
    input  logic [TAG_W-1:0]  cpl_gtag,
    input  logic              cpl_last,
    output logic              cpl_hit,
    output logic [UNIT_W-1:0] cpl_unit,
    output logic [LTAG_W-1:0] cpl_ltag,
    input  logic              crd_rel_valid,
    input  logic [CRED_W-1:0] crd_rel_amt
);

    logic                any_free;
    logic [TAG_W-1:0]    sel_tag;
    logic [NUM_TAGS-1:0] free_map;
    logic [CRED_W-1:0]   credits;
    logic                accept;
    logic                release_en;

    // A completion only counts when its tag is actually outstanding.
    assign cpl_hit    = cpl_valid && !free_map[cpl_gtag];
    assign release_en = cpl_hit && cpl_last;
    assign req_gtag   = sel_tag;

    tag_pool #(.NUM_TAGS(NUM_TAGS)) u_pool (
        .clk      (clk),
        .rst_n    (rst_n),
        .alloc_en (accept),
        .rel_en   (release_en),
        .rel_tag  (cpl_gtag),
        .any_free (any_free),
        .sel_tag  (sel_tag),
        .free_map (free_map)
    );

    credit_counter #(.CAPACITY(CAPACITY)) u_cred (
        .clk      (clk),
        .rst_n    (rst_n),
        .take_en  (accept),
        .take_amt (req_size),
        .give_en  (crd_rel_valid),
        .give_amt (crd_rel_amt),
        .credits  (credits)
    );

    map_table #(.NUM_TAGS(NUM_TAGS), .UNIT_W(UNIT_W), .LTAG_W(LTAG_W)) u_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (accept),
        .wr_tag  (sel_tag),
        .wr_unit (req_unit),
        .wr_ltag (req_ltag),
        .rd_tag  (cpl_gtag),
        .rd_unit (cpl_unit),
        .rd_ltag (cpl_ltag)
    );

    req_gate #(.UNIT_W(UNIT_W), .LTAG_W(LTAG_W), .CAPACITY(CAPACITY)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_unit  (req_unit),
        .req_ltag  (req_ltag),
        .req_size  (req_size),
        .tag_avail (any_free),
        .credits   (credits),
        .req_ready (req_ready),
        .accept    (accept)
    );

    a_r5_no_reuse: assert property (@(posedge clk) disable iff (!rst_n)
        (release_en && accept) |-> (sel_tag != cpl_gtag));

    a_r9_stray: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && free_map[cpl_gtag]) |=> free_map[$past(cpl_gtag)]);

endmodule

// File: tb/sim_tag_remap_alloc.sv
module sim_tag_remap_alloc;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [3:0] req_unit = '0;
    logic [7:0] req_ltag = '0;
    logic [6:0] req_size = '0;
    logic       req_ready;
    logic [4:0] req_gtag;
    logic       cpl_valid = 1'b0;
    logic [4:0] cpl_gtag = '0;
    logic       cpl_last = 1'b0;
    logic       cpl_hit;
    logic [3:0] cpl_unit;
    logic [7:0] cpl_ltag;
    logic       crd_rel_valid = 1'b0;
    logic [6:0] crd_rel_amt = '0;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tag_remap_alloc u0 (.*);

    typedef struct packed {
        logic       rv;   logic [3:0] unit; logic [7:0] ltag; logic [6:0] size;
        logic       cv;   logic [4:0] ctag; logic       clast;
        logic       relv; logic [6:0] rela;
        logic       e_rdy; logic [4:0] e_gtag;
        logic       e_hit; logic [3:0] e_unit; logic [7:0] e_ltag;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 4'd1, 8'h10, 7'd8,  1'b0, 5'd0, 1'b0, 1'b0, 7'd0,  1'b1, 5'd0, 1'b0, 4'd0, 8'h00},
        '{1'b1, 4'd2, 8'h20, 7'd8,  1'b1, 5'd0, 1'b0, 1'b0, 7'd0,  1'b1, 5'd1, 1'b1, 4'd1, 8'h10},
        '{1'b1, 4'd3, 8'h30, 7'd8,  1'b1, 5'd0, 1'b1, 1'b0, 7'd0,  1'b1, 5'd2, 1'b1, 4'd1, 8'h10},
        '{1'b1, 4'd4, 8'h40, 7'd8,  1'b1, 5'd5, 1'b1, 1'b0, 7'd0,  1'b1, 5'd0, 1'b0, 4'd0, 8'h00},
        '{1'b1, 4'd6, 8'h66, 7'd40, 1'b0, 5'd0, 1'b0, 1'b1, 7'd16, 1'b0, 5'd0, 1'b0, 4'd0, 8'h00},
        '{1'b1, 4'd6, 8'h66, 7'd40, 1'b0, 5'd0, 1'b0, 1'b0, 7'd0,  1'b1, 5'd3, 1'b0, 4'd0, 8'h00},
        '{1'b0, 4'd0, 8'h00, 7'd0,  1'b1, 5'd1, 1'b1, 1'b0, 7'd0,  1'b0, 5'd0, 1'b1, 4'd2, 8'h20},
        '{1'b1, 4'd5, 8'h50, 7'd8,  1'b0, 5'd0, 1'b0, 1'b0, 7'd0,  1'b1, 5'd1, 1'b0, 4'd0, 8'h00},
        '{1'b1, 4'd7, 8'h77, 7'd1,  1'b0, 5'd0, 1'b0, 1'b1, 7'd8,  1'b0, 5'd0, 1'b0, 4'd0, 8'h00},
        '{1'b1, 4'd7, 8'h77, 7'd1,  1'b0, 5'd0, 1'b0, 1'b0, 7'd0,  1'b1, 5'd4, 1'b0, 4'd0, 8'h00}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        req_valid = 1'b0; req_unit = '0; req_ltag = '0; req_size = '0;
        cpl_valid = 1'b0; cpl_gtag = '0; cpl_last = 1'b0;
        crd_rel_valid = 1'b0; crd_rel_amt = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle_inputs();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(10 * 200000);
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: fresh pool and full credit
        req_valid = 1'b1; req_size = 7'd64;
        #1;
        chk("R1 ready full capacity", 32'(req_ready), 32'd1);
        chk("R1 first tag", 32'(req_gtag), 32'd0);
        req_valid = 1'b0; req_size = '0;

        // Vector walk (R2 R3 R4 R5 R7 R8 R9)
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            req_valid = VEC[v].rv; req_unit = VEC[v].unit;
            req_ltag = VEC[v].ltag; req_size = VEC[v].size;
            cpl_valid = VEC[v].cv; cpl_gtag = VEC[v].ctag; cpl_last = VEC[v].clast;
            crd_rel_valid = VEC[v].relv; crd_rel_amt = VEC[v].rela;
            #1;
            if (VEC[v].rv) begin
                chk($sformatf("R7 ready v%0d", v), 32'(req_ready), 32'(VEC[v].e_rdy));
                if (VEC[v].e_rdy)
                    chk($sformatf("R2 R5 gtag v%0d", v), 32'(req_gtag), 32'(VEC[v].e_gtag));
            end
            if (VEC[v].cv) begin
                chk($sformatf("R9 hit v%0d", v), 32'(cpl_hit), 32'(VEC[v].e_hit));
                if (VEC[v].e_hit) begin
                    chk($sformatf("R3 unit v%0d", v), 32'(cpl_unit), 32'(VEC[v].e_unit));
                    chk($sformatf("R3 ltag v%0d", v), 32'(cpl_ltag), 32'(VEC[v].e_ltag));
                end
            end
        end
        @(negedge clk);
        idle_inputs();

        // Exhaustion: 32 requests of 2 credits each use all tags and credit (R2, R6)
        do_reset();
        for (int i = 0; i < 32; i++) begin
            req_valid = 1'b1; req_unit = 4'(i); req_ltag = 8'(i); req_size = 7'd2;
            #1;
            chk($sformatf("R2 fill ready %0d", i), 32'(req_ready), 32'd1);
            chk($sformatf("R2 fill tag %0d", i), 32'(req_gtag), 32'(i));
            @(negedge clk);
        end
        req_unit = 4'hA; req_ltag = 8'hAA; req_size = 7'd0;
        #1;
        chk("R6 no free tag", 32'(req_ready), 32'd0);
        @(negedge clk);
        cpl_valid = 1'b1; cpl_gtag = 5'd7; cpl_last = 1'b0;
        #1;
        chk("R3 lookup tag7 unit", 32'(cpl_unit), 32'd7);
        @(negedge clk);
        cpl_valid = 1'b0;
        #1;
        chk("R4 non-last keeps tag", 32'(req_ready), 32'd0);
        @(negedge clk);
        cpl_valid = 1'b1; cpl_gtag = 5'd7; cpl_last = 1'b1;
        #1;
        chk("R5 freed tag not same cycle", 32'(req_ready), 32'd0);
        @(negedge clk);
        cpl_valid = 1'b0; cpl_last = 1'b0;
        #1;
        chk("R4 last frees tag ready", 32'(req_ready), 32'd1);
        chk("R4 freed tag reused", 32'(req_gtag), 32'd7);
        @(negedge clk);
        req_valid = 1'b0;
        cpl_valid = 1'b1; cpl_gtag = 5'd7;
        #1;
        chk("R3 new owner unit", 32'(cpl_unit), 32'hA);
        chk("R3 new owner ltag", 32'(cpl_ltag), 32'hAA);
        @(negedge clk);
        idle_inputs();

        // Reset mid-run restores pool and credit (R1)
        do_reset();
        req_valid = 1'b1; req_size = 7'd64;
        #1;
        chk("R1 re-reset ready", 32'(req_ready), 32'd1);
        chk("R1 re-reset tag", 32'(req_gtag), 32'd0);
        @(negedge clk);
        req_size = 7'd1;
        #1;
        chk("R7 credit drained", 32'(req_ready), 32'd0);
        crd_rel_valid = 1'b1; crd_rel_amt = 7'd1;
        #1;
        chk("R8 release not same cycle", 32'(req_ready), 32'd0);
        @(negedge clk);
        crd_rel_valid = 1'b0;
        #1;
        chk("R8 release next cycle", 32'(req_ready), 32'd1);
        chk("R2 second tag", 32'(req_gtag), 32'd1);
        @(negedge clk);
        idle_inputs();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule